// File: doc/BRIEF.md
# Converter Reset and Sync Controller

This block is the device-side reset and synchronisation logic of a sigma-delta converter. It runs on the master clock. It watches two things: the serial data line, sampled on rising serial-clock edges after both pins pass through a two-flop synchroniser, and an active-low sync pin. From these it drives three controls:

- a register-defaults reset strobe;
- a hold for the decimation filter and modulator;
- an access-blocked flag, which gates incoming register frames.

A run of ones on the data line, or power-up, restores every register to its default and restarts the filter. The sync pin restarts only the filter and modulator and leaves register setup alone. After sync is released, the hold drops on a falling master-clock edge. A small data-ready timer then models the converter's output cadence. It withholds the first ready pulse for a settling time of four output periods, then pulses once per output period. The modulator, the filter arithmetic and the register contents live elsewhere. They see this block only through the reset and hold outputs.

Top module: `conv_reset_sync_ctrl`

## Requirements
- R1: When RUN_LEN (default 40) consecutive data bits of value 1 are sampled on serial-clock rising edges, reg_rst is high for exactly one master clock. A run of RUN_LEN-1 ones followed by a 0 gives no pulse.
- R2: Any sampled 0 bit restarts the ones count. A run of any length beyond RUN_LEN gives a single reg_rst pulse. Broken runs shorter than RUN_LEN give none.
- R3: While por_n is low, reg_rst, filt_hold and acc_blocked are 1, and drdy and frame_ok are 0.
- R4: After the last master-clock sample in which reg_rst is high, acc_blocked stays high for exactly BLOCK_CYC further rising-edge samples, then goes low.
- R5: frame_ok equals frame_req while acc_blocked is low, and is 0 while acc_blocked is high.
- R6: Once sync_n has been low for at least MIN_LOW (default 4) master clocks, filt_hold goes high and stays high while sync_n stays low. A shorter low pulse leaves filt_hold low. Sync activity never raises reg_rst.
- R7: filt_hold changes only on falling master-clock edges. After sync_n rises, filt_hold is still high just before the falling edge that follows the third rising edge, and low just after that falling edge.
- R8: After filt_hold falls, drdy first goes high on the T-th rising edge, where T = 4 × ODR_DIV. After that it pulses every ODR_DIV rising edges. Each pulse lasts one master clock, and drdy is 0 while held.
- R9: A serial-pattern reset also raises filt_hold, so the settling period restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| sclk | input | 1 | Serial clock pin, asynchronous to mclk |
| sdin | input | 1 | Serial data pin, sampled on sclk rising edges |
| sync_n | input | 1 | Active-low synchronisation pin |
| frame_req | input | 1 | A register frame is being presented by the serial interface |
| reg_rst | output | 1 | Restore all registers to defaults |
| filt_hold | output | 1 | Hold filter and modulator in reset (changes on mclk falling edges) |
| acc_blocked | output | 1 | Register access is not yet allowed |
| frame_ok | output | 1 | Frame accepted by the interface |
| drdy | output | 1 | One-clock data-ready pulse |

## Verification
The bench sweeps run lengths from three below to two above the reset count, each terminated by a zero. An off-by-one detector would fire on the short run or miss the exact one. A non-saturating counter would fire twice on 85 ones. It also sweeps sync-low widths from one to seven clocks. A qualifier counting one stage too few or too many would hold on the three-clock pulse or miss the four-clock one. It probes filt_hold half a cycle either side of the release falling edge, which catches a hold registered on the rising edge. It times the first and later ready pulses against four and one output periods, which catches a settle count that is too short or not restarted.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic {
    PH_SETTLE = 1'b0,
    PH_RUN    = 1'b1
  } drdy_phase_e;

  // clocks from hold release to the first ready pulse
  function automatic int unsigned settle_len(int unsigned odr_div, int unsigned periods);
    return odr_div * periods;
  endfunction

  // increment that sticks at its limit
  function automatic int unsigned sat_step(int unsigned cur, int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

endpackage

// File: rtl/crs_sync2.sv
module crs_sync2 #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= {W{RST_VAL}};
      stab_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/crs_run_detect.sv
module crs_run_detect import crs_pkg::*; #(
  parameter int RUN_LEN = 40
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sclk_s,
  input  logic sdin_s,
  output logic trig_o
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic          sclk_d;
  logic [CW-1:0] ones_q;
  logic          bit_edge;
  logic          zero_bit;
  logic          run_done;

  assign bit_edge = sclk_s & ~sclk_d;
  assign zero_bit = bit_edge & ~sdin_s;
  assign run_done = bit_edge & sdin_s & (ones_q == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sclk_d <= 1'b0;
      ones_q <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (zero_bit)
        ones_q <= '0;
      else if (bit_edge)
        ones_q <= CW'(sat_step(32'(ones_q), RUN_LEN));
    end
  end

  assign trig_o = run_done;

  // R2: a zero bit empties the count
  a_r2_zero_clears: assert property (@(posedge clk) disable iff (!arst_n)
    zero_bit |=> (ones_q == '0));

  // R2: the count never passes the run length
  a_r2_count_capped: assert property (@(posedge clk) disable iff (!arst_n)
    ones_q <= CW'(RUN_LEN));

endmodule

// File: rtl/crs_sync_hold.sv
module crs_sync_hold import crs_pkg::*; #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sync_s,
  input  logic force_i,
  output logic hold_o
);

  localparam int LW = $clog2(MIN_LOW + 1);
  localparam logic [LW-1:0] QUAL = LW'(MIN_LOW);

  logic [LW-1:0] low_q;
  logic          sync_qual;
  logic          hold_req;
  logic          hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      low_q <= '0;
    else if (sync_s)
      low_q <= '0;
    else
      low_q <= LW'(sat_step(32'(low_q), MIN_LOW));
  end

  assign sync_qual = (low_q == QUAL);
  assign hold_req  = force_i | sync_qual;

  // the release lands on the falling edge after the request drops
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n)
      hold_q <= 1'b1;
    else
      hold_q <= hold_req;
  end

  assign hold_o = hold_q;

  // R6: a qualified low only exists after the pin was seen low
  a_r6_qual_after_low: assert property (@(posedge clk) disable iff (!arst_n)
    sync_qual |-> !$past(sync_s));

endmodule

// File: rtl/crs_drdy_timer.sv
module crs_drdy_timer import crs_pkg::*; #(
  parameter int ODR_DIV    = 16,
  parameter int SETTLE_PER = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold_i,
  output logic drdy_o
);

  localparam int SETTLE_CYC = settle_len(ODR_DIV, SETTLE_PER);
  localparam int DW = $clog2(SETTLE_CYC + 1);
  localparam logic [DW-1:0] SET_LAST = DW'(SETTLE_CYC - 1);
  localparam logic [DW-1:0] ODR_LAST = DW'(ODR_DIV - 1);

  drdy_phase_e   phase_q;
  logic [DW-1:0] cnt_q;
  logic          drdy_q;
  logic          period_end;

  assign period_end = (cnt_q == ((phase_q == PH_SETTLE) ? SET_LAST : ODR_LAST));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= PH_SETTLE;
      cnt_q   <= '0;
      drdy_q  <= 1'b0;
    end else if (hold_i) begin
      phase_q <= PH_SETTLE;
      cnt_q   <= '0;
      drdy_q  <= 1'b0;
    end else begin
      drdy_q <= period_end;
      if (period_end) begin
        cnt_q   <= '0;
        phase_q <= PH_RUN;
      end else begin
        cnt_q <= cnt_q + DW'(1);
      end
    end
  end

  assign drdy_o = drdy_q;

  // R8: each ready pulse lasts a single clock
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!arst_n)
    (ODR_DIV > 1 && drdy_q) |=> !drdy_q);

endmodule

// File: rtl/conv_reset_sync_ctrl.sv
module conv_reset_sync_ctrl import crs_pkg::*; #(
  parameter int RUN_LEN    = 40,
  parameter int MIN_LOW    = 4,
  parameter int BLOCK_CYC  = 2458,
  parameter int ODR_DIV    = 16,
  parameter int SETTLE_PER = 4
) (
  input  logic mclk,
  input  logic por_n,
  input  logic sclk,
  input  logic sdin,
  input  logic sync_n,
  input  logic frame_req,
  output logic reg_rst,
  output logic filt_hold,
  output logic acc_blocked,
  output logic frame_ok,
  output logic drdy
);

  localparam int BW = $clog2(BLOCK_CYC + 1);
  localparam logic [BW-1:0] BLK_LOAD = BW'(BLOCK_CYC);

  logic [1:0]    ser_s;
  logic          sync_s;
  logic          run_trig;
  logic          rst_q;
  logic [BW-1:0] blk_q;

  crs_sync2 #(.W(2), .RST_VAL(1'b0)) u_ser_sync (
    .clk    (mclk),
    .arst_n (por_n),
    .d      ({sclk, sdin}),
    .q      (ser_s)
  );

  crs_sync2 #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
    .clk    (mclk),
    .arst_n (por_n),
    .d      (sync_n),
    .q      (sync_s)
  );

  crs_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk    (mclk),
    .arst_n (por_n),
    .sclk_s (ser_s[1]),
    .sdin_s (ser_s[0]),
    .trig_o (run_trig)
  );

  // power-up reset and pattern reset share one strobe
  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n)
      rst_q <= 1'b1;
    else
      rst_q <= run_trig;
  end

  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n)
      blk_q <= BLK_LOAD;
    else if (rst_q)
      blk_q <= BLK_LOAD;
    else if (blk_q != '0)
      blk_q <= blk_q - BW'(1);
  end

  crs_sync_hold #(.MIN_LOW(MIN_LOW)) u_hold (
    .clk     (mclk),
    .arst_n  (por_n),
    .sync_s  (sync_s),
    .force_i (rst_q),
    .hold_o  (filt_hold)
  );

  crs_drdy_timer #(.ODR_DIV(ODR_DIV), .SETTLE_PER(SETTLE_PER)) u_drdy (
    .clk    (mclk),
    .arst_n (por_n),
    .hold_i (filt_hold),
    .drdy_o (drdy)
  );

  assign reg_rst     = rst_q;
  assign acc_blocked = (blk_q != '0);
  assign frame_ok    = frame_req & ~acc_blocked;

  // R4: a reset strobe always opens the blocked window
  a_r4_blocked_after_reset: assert property (@(posedge mclk) disable iff (!por_n)
    rst_q |=> acc_blocked);

  // R9: a reset strobe silences data-ready through the hold
  a_r9_reset_quiets_drdy: assert property (@(posedge mclk) disable iff (!por_n)
    rst_q |-> ##2 !drdy);

endmodule

// File: tb/tb_conv_reset_sync_ctrl.sv
module tb_conv_reset_sync_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int P_RUN   = 40;
  localparam int P_LOW   = 4;
  localparam int P_BLOCK = 20;
  localparam int P_ODR   = 5;
  localparam int P_SET   = 4;
  localparam int T_FIRST = P_SET * P_ODR;

  logic mclk = 1'b0;
  logic por_n, sclk, sdin, sync_n, frame_req;
  logic reg_rst, filt_hold, acc_blocked, frame_ok, drdy;

  int total = 0;
  int bad = 0;
  int rst_cnt = 0;
  int hold_seen = 0;
  int last_run = -1;
  int blk_run = 0;
  bit armed = 1'b0;

  conv_reset_sync_ctrl #(
    .RUN_LEN(P_RUN), .MIN_LOW(P_LOW), .BLOCK_CYC(P_BLOCK),
    .ODR_DIV(P_ODR), .SETTLE_PER(P_SET)
  ) dut (
    .mclk(mclk), .por_n(por_n), .sclk(sclk), .sdin(sdin), .sync_n(sync_n),
    .frame_req(frame_req), .reg_rst(reg_rst), .filt_hold(filt_hold),
    .acc_blocked(acc_blocked), .frame_ok(frame_ok), .drdy(drdy)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic tick();
    @(posedge mclk);
    #3;
  endtask

  // observer of pulses, hold activity and blocked-window length
  always @(posedge mclk) begin
    #3;
    if (reg_rst === 1'b1) begin
      rst_cnt++;
      armed = 1'b1;
      blk_run = 0;
    end else if (armed) begin
      if (acc_blocked === 1'b1) blk_run++;
      else begin
        last_run = blk_run;
        armed = 1'b0;
      end
    end
    if (filt_hold === 1'b1) hold_seen = 1;
  end

  task automatic send_bit(input logic b);
    sdin = b;
    sclk = 1'b0;
    repeat (3) tick();
    sclk = 1'b1;
    repeat (3) tick();
  endtask

  // sample index 1 is the first sample with the hold low
  task automatic drdy_after_release(input string tag);
    int guard = 0;
    int first_hi = -1;
    int pulses = 0;
    do begin
      tick();
      guard++;
    end while (filt_hold !== 1'b0 && guard < 1000);
    for (int i = 1; i <= T_FIRST + 2 * P_ODR; i++) begin
      if (i > 1) tick();
      if (drdy === 1'b1) begin
        pulses++;
        if (first_hi < 0) first_hi = i;
      end
    end
    check_eq({tag, " first drdy index"}, first_hi, T_FIRST);
    check_eq({tag, " drdy pulse count"}, pulses, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    por_n = 1'b0; sync_n = 1'b1; sclk = 1'b0; sdin = 1'b0; frame_req = 1'b1;
    repeat (3) tick();
    check_eq("R3 reg_rst in power-up", int'(reg_rst), 1);
    check_eq("R3 filt_hold in power-up", int'(filt_hold), 1);
    check_eq("R3 acc_blocked in power-up", int'(acc_blocked), 1);
    check_eq("R3 drdy in power-up", int'(drdy), 0);
    check_eq("R5 frame_ok in power-up", int'(frame_ok), 0);

    por_n = 1'b1;
    drdy_after_release("R8 after power-up");
    check_eq("R4 blocked window after power-up", last_run, P_BLOCK);
    check_eq("R5 frame passes when open", int'(frame_ok), 1);
    frame_req = 1'b0;
    #1;
    check_eq("R5 no frame no accept", int'(frame_ok), 0);
    frame_req = 1'b1;

    // R6: sweep sync low widths
    for (int len = 1; len <= 7; len++) begin
      hold_seen = 0;
      rst_cnt = 0;
      sync_n = 1'b0;
      repeat (len) tick();
      sync_n = 1'b1;
      repeat (10) tick();
      check_eq($sformatf("R6 hold for low width %0d", len), hold_seen, (len >= P_LOW) ? 1 : 0);
      check_eq($sformatf("R6 no reg_rst for low width %0d", len), rst_cnt, 0);
    end

    // R7: release on the falling edge, then R8 settling
    repeat (40) tick();
    sync_n = 1'b0;
    repeat (10) tick();
    check_eq("R6 held while low", int'(filt_hold), 1);
    check_eq("R8 drdy quiet in hold", int'(drdy), 0);
    repeat (10) tick();
    check_eq("R6 still held", int'(filt_hold), 1);
    sync_n = 1'b1;
    repeat (3) tick();
    check_eq("R7 hold before falling edge", int'(filt_hold), 1);
    #4;
    check_eq("R7 hold after falling edge", int'(filt_hold), 0);
    drdy_after_release("R8 after sync");

    // R1/R2: sweep run lengths around the threshold
    for (int len = P_RUN - 3; len <= P_RUN + 2; len++) begin
      rst_cnt = 0;
      hold_seen = 0;
      last_run = -1;
      send_bit(1'b0);
      repeat (len) send_bit(1'b1);
      send_bit(1'b0);
      repeat (P_BLOCK + 10) tick();
      check_eq($sformatf("R1 pulses for run %0d", len), rst_cnt, (len >= P_RUN) ? 1 : 0);
      if (len >= P_RUN) begin
        check_eq($sformatf("R4 window after run %0d", len), last_run, P_BLOCK);
        check_eq($sformatf("R9 hold after run %0d", len), hold_seen, 1);
      end
    end

    // R2: broken runs and one very long run
    rst_cnt = 0;
    send_bit(1'b0);
    repeat (30) send_bit(1'b1);
    send_bit(1'b0);
    repeat (30) send_bit(1'b1);
    send_bit(1'b0);
    repeat (5) tick();
    check_eq("R2 broken runs give no reset", rst_cnt, 0);
    rst_cnt = 0;
    repeat (85) send_bit(1'b1);
    send_bit(1'b0);
    repeat (P_BLOCK + 10) tick();
    check_eq("R2 long run gives one reset", rst_cnt, 1);

    // R5: frame refused inside the window
    send_bit(1'b0);
    repeat (P_RUN) send_bit(1'b1);
    tick();
    check_eq("R5 blocked after pattern reset", int'(acc_blocked), 1);
    check_eq("R5 frame refused while blocked", int'(frame_ok), 0);
    sdin = 1'b0;
    sclk = 1'b0;
    drdy_after_release("R9 settle restarts after pattern reset");

    finish_run();
  end

endmodule